// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Collector

This block gathers the per-channel event pulses of a multi-channel DMA engine (a descriptor finished cleanly, a data transfer met a bus error, a descriptor was malformed, a channel timed out, a descriptor status write-back finished) and turns them into sticky per-channel flag bits and one interrupt line. Four levels of enabling decide whether an event raises a flag. A global enable overrides everything. An error enable admits error events. A per-channel mask admits completion events. A per-descriptor request bit marks the completions that should interrupt at all.

When the engine writes a descriptor's status back to memory, the flag for that descriptor is held back until the engine reports that the write-back is done. In the meantime the block drives the error field that the engine must place in the written-back status. A separate error register records the kind and the channel of the first error since it was last cleared. Software clears flags by writing ones. The flag register, the enables and the error register are presented as plain ports, so a register bank can wrap them.

Top module: `dma_irq_top`

## Requirements
- R1: While `globalIrqEn` is 0, `irq` is 0 and no flag bit becomes newly set, whatever events arrive. Flags already set stay set.
- R2: An error event raises its channel's flag only when `globalIrqEn` and `errIrqEn` are both 1. The channel's completion mask bit has no effect on error flags.
- R3: A clean completion (`descDone` with no error on that channel) raises its channel's flag only when `descIrqReq` and `chanMask` for that channel are both 1, and the global enable is 1.
- R4: For an event that arrives while `wbEnable` is set, the flag rises only on the clock edge that samples `wbDone` for that channel. The enables are evaluated at that edge.
- R5: When write-back is disabled, a qualifying event sets the flag on the clock edge that samples it. `irq` equals `globalIrqEn` ANDed with the OR of all flag bits, with no added register.
- R6: `wbErrBit[c]` is 1 from the edge that samples an error with write-back enabled on channel c until the edge that samples `wbDone[c]`.
- R7: Each bit set in the one-cycle `flagClr` vector clears that flag (write one to clear). Zero bits leave their flags unchanged.
- R8: If a flag is cleared and set in the same cycle, it stays set.
- R9: The error register captures the first error while `errValid` is 0 and holds it until `errClr`. It captures errors even when interrupts are disabled. The kind is coded as 0 = none, 1 = transfer, 2 = descriptor, 3 = timeout. An error that arrives with `errClr` in the same cycle is captured.
- R10: Among errors that arrive in the same cycle, the lowest channel index is recorded. Within a channel, transfer has priority over descriptor, and descriptor over timeout.
- R11: A `descDone` that coincides with an error on the same channel is treated only as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| globalIrqEn | input | 1 | Master interrupt enable |
| errIrqEn | input | 1 | Enable for error interrupts |
| chanMask | input | NUM_CH | Completion interrupt mask per channel (1 = allow) |
| descDone | input | NUM_CH | Descriptor completed pulse |
| descIrqReq | input | NUM_CH | Descriptor interrupt request bit, valid with descDone |
| xferErr | input | NUM_CH | Bus error during a data transfer pulse |
| descErr | input | NUM_CH | Descriptor error pulse |
| timeoutErr | input | NUM_CH | Timeout error pulse |
| wbEnable | input | NUM_CH | Status write-back enabled for the event in this cycle |
| wbDone | input | NUM_CH | Status write-back finished pulse |
| flagClr | input | NUM_CH | One-cycle write-one-to-clear of the flags |
| errClr | input | 1 | Clear the error register |
| irq | output | 1 | Interrupt line |
| irqFlags | output | NUM_CH | Sticky per-channel interrupt flags |
| wbErrBit | output | NUM_CH | Error field value for the pending written-back status |
| errValid | output | 1 | Error register holds an error |
| errKind | output | 2 | Recorded error kind |
| errChan | output | CHAN_W | Recorded error channel |

## Verification
The assertions assume that every event input is a single-cycle pulse. They also assume that a channel does not raise a new event while a write-back for that channel is still pending, and that `wbDone` never arrives in the same cycle as the event it completes. The bench drives every pulse for exactly one cycle on the falling edge. It gives each deferred event its `wbDone` only in a later cycle, and it waits for each write-back to finish before it starts the next event on that channel.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_XFER = 2'd1,
    ERR_DESC = 2'd2,
    ERR_TMO  = 2'd3
  } errKind_e;

  typedef struct packed {
    logic     errCapture;
    errKind_e errKind;
  } ctrlStrobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHAN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalIrqEn,
  input  logic              errIrqEn,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [NUM_CH-1:0] descDone,
  input  logic [NUM_CH-1:0] descIrqReq,
  input  logic [NUM_CH-1:0] xferErr,
  input  logic [NUM_CH-1:0] descErr,
  input  logic [NUM_CH-1:0] timeoutErr,
  input  logic [NUM_CH-1:0] wbEnable,
  input  logic [NUM_CH-1:0] wbDone,
  output logic [NUM_CH-1:0] setFlag,
  output logic [NUM_CH-1:0] wbErrBit,
  output logic [CHAN_W-1:0] errChanSel,
  output ctrlStrobe_t       strobe
);

  logic [NUM_CH-1:0] errAny;
  logic              errGate;

  assign errAny  = xferErr | descErr | timeoutErr;
  assign errGate = globalIrqEn & errIrqEn;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    logic pendCmp;
    logic pendErr;
    logic cmpOk;
    logic cmpGate;
    logic cmpFire;
    logic errFire;

    // a completion counts only when it carries a request and no error
    assign cmpOk   = descDone[c] & descIrqReq[c] & ~errAny[c];
    assign cmpGate = globalIrqEn & chanMask[c];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCmp <= 1'b0;
        pendErr <= 1'b0;
      end else begin
        if (wbDone[c]) begin
          pendCmp <= 1'b0;
          pendErr <= 1'b0;
        end
        if (wbEnable[c]) begin
          if (cmpOk)     pendCmp <= 1'b1;
          if (errAny[c]) pendErr <= 1'b1;
        end
      end
    end

    assign cmpFire    = (cmpOk & ~wbEnable[c]) | (wbDone[c] & pendCmp);
    assign errFire    = (errAny[c] & ~wbEnable[c]) | (wbDone[c] & pendErr);
    assign setFlag[c] = (cmpFire & cmpGate) | (errFire & errGate);
    assign wbErrBit[c] = pendErr;

    // R4: a deferred event never sets its flag in its own cycle
    assert_wb_defer_R4: assert property (@(posedge clk) disable iff (!rstN)
      ((descDone[c] | errAny[c]) && wbEnable[c] && !wbDone[c]) |-> !setFlag[c]);

    // R6: a deferred error marks the status error field on the next cycle
    assert_wb_errbit_R6: assert property (@(posedge clk) disable iff (!rstN)
      (errAny[c] && wbEnable[c]) |=> wbErrBit[c]);

    // R11: an error in the same cycle suppresses a completion-only flag
    assert_err_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
      (descDone[c] && errAny[c] && !errGate && !wbDone[c]) |-> !setFlag[c]);
  end

  // first-error selection: lowest channel, then transfer > descriptor > timeout
  always_comb begin
    logic found;
    found      = 1'b0;
    errChanSel = '0;
    strobe     = '{errCapture: 1'b0, errKind: ERR_NONE};
    for (int c = 0; c < NUM_CH; c++) begin
      if (!found && errAny[c]) begin
        found             = 1'b1;
        errChanSel        = CHAN_W'(c);
        strobe.errCapture = 1'b1;
        if (xferErr[c])      strobe.errKind = ERR_XFER;
        else if (descErr[c]) strobe.errKind = ERR_DESC;
        else                 strobe.errKind = ERR_TMO;
      end
    end
  end

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> (setFlag == '0));

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHAN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalIrqEn,
  input  logic [NUM_CH-1:0] setFlag,
  input  logic [NUM_CH-1:0] flagClr,
  input  logic              errClr,
  input  logic [CHAN_W-1:0] errChanSel,
  input  ctrlStrobe_t       strobe,
  output logic              irq,
  output logic [NUM_CH-1:0] irqFlags,
  output logic              errValid,
  output errKind_e          errKind,
  output logic [CHAN_W-1:0] errChan
);

  logic [NUM_CH-1:0] flagReg;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~flagClr) | setFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errKind  <= ERR_NONE;
      errChan  <= '0;
    end else if (strobe.errCapture && (!errValid || errClr)) begin
      errValid <= 1'b1;
      errKind  <= strobe.errKind;
      errChan  <= errChanSel;
    end else if (errClr) begin
      errValid <= 1'b0;
      errKind  <= ERR_NONE;
      errChan  <= '0;
    end
  end

  assign irqFlags = flagReg;
  assign irq      = globalIrqEn & (|flagReg);

  assert_no_new_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |=> ((irqFlags & ~$past(irqFlags)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (setFlag != '0) |=> ((irqFlags & $past(setFlag)) == $past(setFlag)));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errClr) |=> (errValid && $stable(errKind) && $stable(errChan)));

  assert_err_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errKind != ERR_NONE));

endmodule

// File: rtl/dma_irq_top.sv
module dma_irq_top
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHAN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalIrqEn,
  input  logic              errIrqEn,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [NUM_CH-1:0] descDone,
  input  logic [NUM_CH-1:0] descIrqReq,
  input  logic [NUM_CH-1:0] xferErr,
  input  logic [NUM_CH-1:0] descErr,
  input  logic [NUM_CH-1:0] timeoutErr,
  input  logic [NUM_CH-1:0] wbEnable,
  input  logic [NUM_CH-1:0] wbDone,
  input  logic [NUM_CH-1:0] flagClr,
  input  logic              errClr,
  output logic              irq,
  output logic [NUM_CH-1:0] irqFlags,
  output logic [NUM_CH-1:0] wbErrBit,
  output logic              errValid,
  output logic [1:0]        errKind,
  output logic [CHAN_W-1:0] errChan
);

  logic [NUM_CH-1:0] setFlag;
  logic [CHAN_W-1:0] errChanSel;
  ctrlStrobe_t       strobe;
  errKind_e          errKindReg;

  dma_irq_ctrl #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .globalIrqEn(globalIrqEn),
    .errIrqEn   (errIrqEn),
    .chanMask   (chanMask),
    .descDone   (descDone),
    .descIrqReq (descIrqReq),
    .xferErr    (xferErr),
    .descErr    (descErr),
    .timeoutErr (timeoutErr),
    .wbEnable   (wbEnable),
    .wbDone     (wbDone),
    .setFlag    (setFlag),
    .wbErrBit   (wbErrBit),
    .errChanSel (errChanSel),
    .strobe     (strobe)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .globalIrqEn(globalIrqEn),
    .setFlag    (setFlag),
    .flagClr    (flagClr),
    .errClr     (errClr),
    .errChanSel (errChanSel),
    .strobe     (strobe),
    .irq        (irq),
    .irqFlags   (irqFlags),
    .errValid   (errValid),
    .errKind    (errKindReg),
    .errChan    (errChan)
  );

  assign errKind = errKindReg;

endmodule

// File: tb/tb_dma_irq_top.sv
module tb_dma_irq_top;

  localparam int NUM_CH = 4;
  localparam int CHAN_W = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalIrqEn = 1'b0, errIrqEn = 1'b0, errClr = 1'b0;
  logic [NUM_CH-1:0] chanMask = '0, descDone = '0, descIrqReq = '0;
  logic [NUM_CH-1:0] xferErr = '0, descErr = '0, timeoutErr = '0;
  logic [NUM_CH-1:0] wbEnable = '0, wbDone = '0, flagClr = '0;
  logic irq, errValid;
  logic [NUM_CH-1:0] irqFlags, wbErrBit;
  logic [1:0] errKind;
  logic [CHAN_W-1:0] errChan;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_top #(.NUM_CH(NUM_CH)) dut (
    .clk(clk), .rstN(rstN), .globalIrqEn(globalIrqEn), .errIrqEn(errIrqEn),
    .chanMask(chanMask), .descDone(descDone), .descIrqReq(descIrqReq),
    .xferErr(xferErr), .descErr(descErr), .timeoutErr(timeoutErr),
    .wbEnable(wbEnable), .wbDone(wbDone), .flagClr(flagClr), .errClr(errClr),
    .irq(irq), .irqFlags(irqFlags), .wbErrBit(wbErrBit), .errValid(errValid),
    .errKind(errKind), .errChan(errChan)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge, then drop every pulse input
  task automatic tick();
    @(negedge clk);
    descDone = '0; descIrqReq = '0; xferErr = '0; descErr = '0;
    timeoutErr = '0; wbDone = '0; flagClr = '0; errClr = 1'b0;
  endtask

  task automatic cleanup();
    flagClr = '1; errClr = 1'b1; tick();
  endtask

  task automatic testReset();
    chk("R5 reset irq", 32'(irq), 0);
    chk("R7 reset flags", 32'(irqFlags), 0);
    chk("R9 reset errValid", 32'(errValid), 0);
  endtask

  task automatic testCompletion();
    globalIrqEn = 1; errIrqEn = 1; chanMask = 4'hF;
    descDone = 4'b0010; descIrqReq = 4'b0010; tick();
    chk("R3 completion flag", 32'(irqFlags), 32'h2);
    chk("R5 irq high", 32'(irq), 1);
    flagClr = 4'b0001; tick();
    chk("R7 zero bit keeps flag", 32'(irqFlags), 32'h2);
    flagClr = 4'b0010; tick();
    chk("R7 clear flag", 32'(irqFlags), 0);
    chk("R5 irq low", 32'(irq), 0);
  endtask

  task automatic testCompletionMask();
    descDone = 4'b0001; descIrqReq = 4'b0000; tick();
    chk("R3 no request bit", 32'(irqFlags), 0);
    chanMask = 4'b1011;
    descDone = 4'b0100; descIrqReq = 4'b0100; tick();
    chk("R3 channel masked", 32'(irqFlags), 0);
    chanMask = 4'hF;
  endtask

  task automatic testGlobal();
    globalIrqEn = 0;
    descDone = 4'b0001; descIrqReq = 4'b0001; xferErr = 4'b1000; tick();
    chk("R1 no flags", 32'(irqFlags), 0);
    chk("R1 irq low", 32'(irq), 0);
    chk("R9 logged while disabled", {errValid, errKind, errChan}, {1'b1, 2'd1, 2'd3});
    errClr = 1; tick();
    globalIrqEn = 1; descDone = 4'b0001; descIrqReq = 4'b0001; tick();
    globalIrqEn = 0; #1;
    chk("R1 irq masked", 32'(irq), 0);
    chk("R1 flag kept", 32'(irqFlags), 32'h1);
    globalIrqEn = 1; #1;
    chk("R5 irq back", 32'(irq), 1);
    cleanup();
  endtask

  task automatic testErrEnable();
    errIrqEn = 0; chanMask = '0;
    descErr = 4'b0100; tick();
    chk("R2 error enable off", 32'(irqFlags), 0);
    errIrqEn = 1;
    timeoutErr = 4'b0100; tick();
    chk("R2 error flag ignores mask", 32'(irqFlags), 32'h4);
    chanMask = 4'hF;
    cleanup();
  endtask

  task automatic testWriteBack();
    wbEnable = 4'b0010;
    descDone = 4'b0010; descIrqReq = 4'b0010; tick();
    chk("R4 deferred", 32'(irqFlags), 0);
    tick();
    chk("R4 still deferred", 32'(irqFlags), 0);
    wbDone = 4'b0010; tick();
    chk("R4 released", 32'(irqFlags), 32'h2);
    wbEnable = 4'b0100;
    xferErr = 4'b0100; tick();
    chk("R4 error deferred", 32'(irqFlags), 32'h2);
    chk("R6 status error bit", 32'(wbErrBit), 32'h4);
    wbDone = 4'b0100; tick();
    chk("R4 error released", 32'(irqFlags), 32'h6);
    chk("R6 status error bit cleared", 32'(wbErrBit), 0);
    wbEnable = '0;
    cleanup();
  endtask

  task automatic testCollision();
    descDone = 4'b0011; descIrqReq = 4'b0011; tick();
    chk("R5 two flags", 32'(irqFlags), 32'h3);
    descDone = 4'b0001; descIrqReq = 4'b0001; flagClr = 4'b0011; tick();
    chk("R8 set beats clear", 32'(irqFlags), 32'h1);
    cleanup();
  endtask

  task automatic testErrRegister();
    descErr = 4'b0100; timeoutErr = 4'b0010; tick();
    chk("R10 lowest channel", {errValid, errKind, errChan}, {1'b1, 2'd3, 2'd1});
    xferErr = 4'b0001; tick();
    chk("R9 first error held", {errValid, errKind, errChan}, {1'b1, 2'd3, 2'd1});
    errClr = 1; tick();
    chk("R9 cleared", {errValid, errKind}, 0);
    xferErr = 4'b1000; descErr = 4'b1000; tick();
    chk("R10 type priority", {errValid, errKind, errChan}, {1'b1, 2'd1, 2'd3});
    errClr = 1; descErr = 4'b0001; tick();
    chk("R9 capture with clear", {errValid, errKind, errChan}, {1'b1, 2'd2, 2'd0});
    cleanup();
  endtask

  task automatic testErrVsDone();
    errIrqEn = 0;
    descDone = 4'b0001; descIrqReq = 4'b0001; xferErr = 4'b0001; tick();
    chk("R11 completion dropped", 32'(irqFlags), 0);
    chk("R11 error recorded", {errValid, errKind}, {1'b1, 2'd1});
    errIrqEn = 1;
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testCompletion();
    testCompletionMask();
    testGlobal();
    testErrEnable();
    testWriteBack();
    testCollision();
    testErrRegister();
    testErrVsDone();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule